// File: doc/BRIEF.md
# UART Host Register Bank with Protected Enhanced Settings

This block is the host-facing register file of a 16550-style UART. A host reaches it through an 8-bit data bus, a 3-bit address and separate read and write strobes. It stores the interrupt-enable, FIFO-control, line-control, modem-control and scratch settings, and drives their current values to the UART core. On top of the plain 16550 set it holds a feature-control register, an enhanced-feature register, an enhanced-mode register, and separate transmit and receive copies of a trigger-level register and a flow-count register. The core reports its transmit and receive FIFO fill levels back to the bank.

The upper bits of the interrupt-enable, FIFO-control and modem-control registers are protected. They change only while a gate bit in the enhanced-feature register is set, and they keep their values once the gate is closed. After reset they are all zero, so the bank looks like a plain 16550. A mode state machine tracks two things: whether the configuration window is open (the line-control register holds 0xBF), and whether the gate is open. Its four states are `ST_LEG_LOCK`, `ST_LEG_OPEN`, `ST_CFG_LOCK` and `ST_CFG_OPEN`. It has four transitions. T_ENTER is a line-control write of 0xBF and moves a legacy state to its configuration twin. T_EXIT is a line-control write of any other value and moves a configuration state to its legacy twin. T_OPEN (enhanced-feature write with bit 4 set) and T_SHUT (the same write with bit 4 clear) move between the two configuration states. Every state keeps its gate through T_ENTER and T_EXIT. Reset enters `ST_LEG_LOCK`.

When the swap bit of the feature-control register is set, the scratch address changes role. A read returns a FIFO fill level, and a write loads the enhanced-mode register. A steering bit in the same register chooses whether the trigger and flow-count addresses reach the transmit or the receive copy.

Top module: `uart_regbank`

## Requirements
- R1: After reset every stored register and output is 0, the state is `ST_LEG_LOCK`, and reads of addresses 1, 2, 3, 4 and 7 return 0x00.
- R2: Outside the configuration window the map is as follows. Address 1 is the interrupt-enable register, address 2 is the FIFO-control register (it reads back its stored value), address 3 is the line-control register, address 4 is the modem-control register and address 7 is the scratch register. Addresses 0, 5 and 6 read 0x00, and writes to them change no register.
- R3: While the line-control register holds 0xBF, address 1 is the feature-control register, address 2 is the enhanced-feature register, address 4 is the trigger register and address 5 is the flow-count register. Address 3 stays the line-control register. Leaving the window restores the legacy map with the legacy registers unchanged.
- R4: While the gate (enhanced-feature bit 4) is 1, a host write changes the whole of interrupt-enable bits 7:4, FIFO-control bits 5:4 and modem-control bits 7:5. While the gate is 0, a write leaves those bits as they were and still updates the other bits of the same register.
- R5: Once the gate is cleared, values written while it was open are retained.
- R6: The enhanced-feature register reads bits 3:0 and bit 5 as 0. Bits 7, 6 and 4 hold their written values, and bit 4 is the gate. The feature-control register reads bits 3:2 as 0.
- R7: With feature-control bit 6 at 0, address 7 is an ordinary read/write scratch register.
- R8: With feature-control bit 6 at 1, a read of address 7 returns a FIFO level, zero-extended. This is the transmit level when feature-control bit 7 is 1 and the receive level when it is 0. A write to address 7 loads the enhanced-mode register and leaves the scratch value unchanged.
- R9: Feature-control bit 7 steers trigger and flow-count accesses: 0 reaches the receive copy and 1 reaches the transmit copy. The other copy does not change.
- R10: The trigger-table select output equals feature-control bits 5:4 (00 to 11 for tables A to D).
- R11: A write takes effect at the rising edge where the write strobe is sampled high. Read data is combinational from the current state and is 0x00 while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Read data |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| lcr_o | output | 8 | Line-control setting |
| ier_o | output | 8 | Interrupt-enable setting |
| fcr_o | output | 8 | FIFO-control setting |
| mcr_o | output | 8 | Modem-control setting |
| flow_en_o | output | 2 | Enhanced-feature bits 7:6 |
| trig_tbl_o | output | 2 | Selected trigger table |
| fctr_aux_o | output | 2 | Feature-control bits 1:0 |
| ems_o | output | 8 | Enhanced-mode register |
| tx_trg_o | output | 8 | Transmit trigger level |
| rx_trg_o | output | 8 | Receive trigger level |
| tx_fc_o | output | 8 | Transmit flow count |
| rx_fc_o | output | 8 | Receive flow count |

## Verification
The assertions take for granted that the FIFO levels never exceed the FIFO depth. They also assume that a single address is presented per cycle, and that a read and a write may share a cycle. The stimulus changes every input only on the falling clock edge. It holds the levels at fixed in-range values and presents one address per strobe. The one cycle that asserts both strobes at once checks the old and new read values on either side of the rising edge.

// File: rtl/ubank_pkg.sv
package ubank_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int N_DIR  = 2;
    localparam int DIR_RX = 0;
    localparam int DIR_TX = 1;

    localparam logic [DATA_W-1:0] CFG_KEY = 8'hBF;

    // legacy map; the configuration window reuses 1, 2, 4 and 5
    localparam logic [ADDR_W-1:0] ADR_IER = 3'd1; // cfg: feature control
    localparam logic [ADDR_W-1:0] ADR_FCR = 3'd2; // cfg: enhanced feature
    localparam logic [ADDR_W-1:0] ADR_LCR = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_MCR = 3'd4; // cfg: trigger level
    localparam logic [ADDR_W-1:0] ADR_AUX = 3'd5; // cfg: flow count
    localparam logic [ADDR_W-1:0] ADR_SCR = 3'd7;

    localparam logic [DATA_W-1:0] IER_PROT  = 8'hF0;
    localparam logic [DATA_W-1:0] FCR_PROT  = 8'h30;
    localparam logic [DATA_W-1:0] MCR_PROT  = 8'hE0;
    localparam logic [DATA_W-1:0] FCTR_KEEP = 8'hF3;
    localparam int GATE_BIT  = 4;
    localparam int SWAP_BIT  = 6;
    localparam int STEER_BIT = 7;

    typedef enum logic [1:0] {
        ST_LEG_LOCK = 2'b00,
        ST_LEG_OPEN = 2'b01,
        ST_CFG_LOCK = 2'b10,
        ST_CFG_OPEN = 2'b11
    } ubank_state_e;

    function automatic logic [DATA_W-1:0] gated_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [DATA_W-1:0] prot,
        input logic              open
    );
        return open ? new_v : ((old_v & prot) | (new_v & ~prot));
    endfunction
endpackage

// File: rtl/ubank_mode_fsm.sv
module ubank_mode_fsm
    import ubank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cfg_win,
    output logic              gate_open
);
    ubank_state_e state_q, state_d;
    logic lcr_wr, efr_wr, key_hit;

    assign lcr_wr  = wr && (addr == ADR_LCR);
    assign efr_wr  = wr && cfg_win && (addr == ADR_FCR);
    assign key_hit = (wdata == CFG_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LEG_LOCK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LEG_LOCK: if (lcr_wr && key_hit) state_d = ST_CFG_LOCK;      // T_ENTER
            ST_LEG_OPEN: if (lcr_wr && key_hit) state_d = ST_CFG_OPEN;      // T_ENTER
            ST_CFG_LOCK: begin
                if (lcr_wr && !key_hit)                state_d = ST_LEG_LOCK; // T_EXIT
                else if (efr_wr && wdata[GATE_BIT])    state_d = ST_CFG_OPEN; // T_OPEN
            end
            ST_CFG_OPEN: begin
                if (lcr_wr && !key_hit)                state_d = ST_LEG_OPEN; // T_EXIT
                else if (efr_wr && !wdata[GATE_BIT])   state_d = ST_CFG_LOCK; // T_SHUT
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_LEG_LOCK: begin cfg_win = 1'b0; gate_open = 1'b0; end
            ST_LEG_OPEN: begin cfg_win = 1'b0; gate_open = 1'b1; end
            ST_CFG_LOCK: begin cfg_win = 1'b1; gate_open = 1'b0; end
            ST_CFG_OPEN: begin cfg_win = 1'b1; gate_open = 1'b1; end
        endcase
    end

    AST_KEY_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr_wr && key_hit) |=> cfg_win); // R3
    AST_OTHER_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr_wr && !key_hit) |=> !cfg_win); // R3
    AST_GATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !efr_wr |=> (gate_open == $past(gate_open))); // R5
endmodule

// File: rtl/ubank_regs.sv
module ubank_regs
    import ubank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cfg_win,
    input  logic              gate_open,
    output logic [DATA_W-1:0] lcr,
    output logic [DATA_W-1:0] ier,
    output logic [DATA_W-1:0] fcr,
    output logic [DATA_W-1:0] mcr,
    output logic [DATA_W-1:0] scr,
    output logic [DATA_W-1:0] ems,
    output logic [DATA_W-1:0] fctr,
    output logic [1:0]        efr_hi,
    output logic [N_DIR-1:0][DATA_W-1:0] trg,
    output logic [N_DIR-1:0][DATA_W-1:0] fc
);
    logic leg_wr, cfg_wr, swap, dir_sel;
    logic w_lcr, w_ier, w_fcr, w_mcr, w_fctr, w_efr, w_trg, w_fc, w_scr, w_ems;

    assign leg_wr  = wr && !cfg_win;
    assign cfg_wr  = wr && cfg_win;
    assign swap    = fctr[SWAP_BIT];
    assign dir_sel = fctr[STEER_BIT];

    assign w_lcr  = wr     && (addr == ADR_LCR);
    assign w_ier  = leg_wr && (addr == ADR_IER);
    assign w_fcr  = leg_wr && (addr == ADR_FCR);
    assign w_mcr  = leg_wr && (addr == ADR_MCR);
    assign w_fctr = cfg_wr && (addr == ADR_IER);
    assign w_efr  = cfg_wr && (addr == ADR_FCR);
    assign w_trg  = cfg_wr && (addr == ADR_MCR);
    assign w_fc   = cfg_wr && (addr == ADR_AUX);
    assign w_scr  = wr && (addr == ADR_SCR) && !swap;
    assign w_ems  = wr && (addr == ADR_SCR) &&  swap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr    <= '0;
            ier    <= '0;
            fcr    <= '0;
            mcr    <= '0;
            scr    <= '0;
            ems    <= '0;
            fctr   <= '0;
            efr_hi <= '0;
        end else begin
            if (w_lcr)  lcr    <= wdata;
            if (w_ier)  ier    <= gated_merge(ier, wdata, IER_PROT, gate_open);
            if (w_fcr)  fcr    <= gated_merge(fcr, wdata, FCR_PROT, gate_open);
            if (w_mcr)  mcr    <= gated_merge(mcr, wdata, MCR_PROT, gate_open);
            if (w_scr)  scr    <= wdata;
            if (w_ems)  ems    <= wdata;
            if (w_fctr) fctr   <= wdata & FCTR_KEEP;
            if (w_efr)  efr_hi <= wdata[7:6];
        end
    end

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        logic hit;
        logic [DATA_W-1:0] trg_r, fc_r;
        assign hit = (int'(dir_sel) == d);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                trg_r <= '0;
                fc_r  <= '0;
            end else begin
                if (w_trg && hit) trg_r <= wdata;
                if (w_fc  && hit) fc_r  <= wdata;
            end
        end
        assign trg[d] = trg_r;
        assign fc[d]  = fc_r;
    end

    AST_IER_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (w_ier && !gate_open) |=> (ier[7:4] == $past(ier[7:4]))); // R4
    AST_MCR_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (w_mcr && !gate_open) |=> (mcr[7:5] == $past(mcr[7:5]))); // R4
    AST_SCR_KEPT_ON_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        w_ems |=> $stable(scr)); // R8
    AST_TX_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ((w_trg || w_fc) && !dir_sel) |=> ($stable(trg[DIR_TX]) && $stable(fc[DIR_TX]))); // R9
    AST_RX_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ((w_trg || w_fc) && dir_sel) |=> ($stable(trg[DIR_RX]) && $stable(fc[DIR_RX]))); // R9
    AST_LEGACY_KEPT_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_win |=> ($stable(ier) && $stable(fcr) && $stable(mcr))); // R3
endmodule

// File: rtl/ubank_rdmux.sv
module ubank_rdmux
    import ubank_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cfg_win,
    input  logic              gate_open,
    input  logic [DATA_W-1:0] lcr,
    input  logic [DATA_W-1:0] ier,
    input  logic [DATA_W-1:0] fcr,
    input  logic [DATA_W-1:0] mcr,
    input  logic [DATA_W-1:0] scr,
    input  logic [DATA_W-1:0] fctr,
    input  logic [1:0]        efr_hi,
    input  logic [N_DIR-1:0][DATA_W-1:0] trg,
    input  logic [N_DIR-1:0][DATA_W-1:0] fc,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] efr_view, lvl_view, trg_sel, fc_sel;
    logic              dir;

    assign dir      = fctr[STEER_BIT];
    assign efr_view = {efr_hi, 1'b0, gate_open, 4'b0000};
    assign lvl_view = dir ? DATA_W'(tx_level) : DATA_W'(rx_level);
    assign trg_sel  = trg[dir];
    assign fc_sel   = fc[dir];

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                ADR_IER: rdata = cfg_win ? (fctr & FCTR_KEEP) : ier;
                ADR_FCR: rdata = cfg_win ? efr_view : fcr;
                ADR_LCR: rdata = lcr;
                ADR_MCR: rdata = cfg_win ? trg_sel : mcr;
                ADR_AUX: rdata = cfg_win ? fc_sel : '0;
                ADR_SCR: rdata = fctr[SWAP_BIT] ? lvl_view : scr;
                default: rdata = '0;
            endcase
        end
    end

    AST_TX_LEVEL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == ADR_SCR && fctr[SWAP_BIT] && fctr[STEER_BIT])
            |-> (rdata == DATA_W'(tx_level))); // R8
    AST_RX_LEVEL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == ADR_SCR && fctr[SWAP_BIT] && !fctr[STEER_BIT])
            |-> (rdata == DATA_W'(rx_level))); // R8
    AST_EFR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && cfg_win && addr == ADR_FCR) |-> (rdata[3:0] == 4'h0 && !rdata[5])); // R6
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import ubank_pkg::*;
#(
    parameter  int FIFO_DEPTH = 64,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [7:0]        host_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    output logic [7:0]        lcr_o,
    output logic [7:0]        ier_o,
    output logic [7:0]        fcr_o,
    output logic [7:0]        mcr_o,
    output logic [1:0]        flow_en_o,
    output logic [1:0]        trig_tbl_o,
    output logic [1:0]        fctr_aux_o,
    output logic [7:0]        ems_o,
    output logic [7:0]        tx_trg_o,
    output logic [7:0]        rx_trg_o,
    output logic [7:0]        tx_fc_o,
    output logic [7:0]        rx_fc_o
);
    logic              cfg_win, gate_open;
    logic [DATA_W-1:0] scr, fctr;
    logic [N_DIR-1:0][DATA_W-1:0] trg, fc;

    ubank_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (host_wr),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .cfg_win   (cfg_win),
        .gate_open (gate_open)
    );

    ubank_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (host_wr),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .cfg_win   (cfg_win),
        .gate_open (gate_open),
        .lcr       (lcr_o),
        .ier       (ier_o),
        .fcr       (fcr_o),
        .mcr       (mcr_o),
        .scr       (scr),
        .ems       (ems_o),
        .fctr      (fctr),
        .efr_hi    (flow_en_o),
        .trg       (trg),
        .fc        (fc)
    );

    ubank_rdmux #(.LVL_W(LVL_W)) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (host_rd),
        .addr      (host_addr),
        .cfg_win   (cfg_win),
        .gate_open (gate_open),
        .lcr       (lcr_o),
        .ier       (ier_o),
        .fcr       (fcr_o),
        .mcr       (mcr_o),
        .scr       (scr),
        .fctr      (fctr),
        .efr_hi    (flow_en_o),
        .trg       (trg),
        .fc        (fc),
        .tx_level  (tx_level),
        .rx_level  (rx_level),
        .rdata     (host_rdata)
    );

    assign trig_tbl_o = fctr[5:4];
    assign fctr_aux_o = fctr[1:0];
    assign tx_trg_o   = trg[DIR_TX];
    assign rx_trg_o   = trg[DIR_RX];
    assign tx_fc_o    = fc[DIR_TX];
    assign rx_fc_o    = fc[DIR_RX];

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_level) <= FIFO_DEPTH && int'(rx_level) <= FIFO_DEPTH)); // R8
    AST_TABLE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && cfg_win && host_addr == ADR_IER) |=> $stable(trig_tbl_o)); // R10
endmodule

// File: tb/test_uart_regbank.sv
module test_uart_regbank;
    localparam int LVL_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic [LVL_W-1:0] tx_level = 7'd40, rx_level = 7'd17;
    logic [7:0] lcr_o, ier_o, fcr_o, mcr_o, ems_o, tx_trg_o, rx_trg_o, tx_fc_o, rx_fc_o;
    logic [1:0] flow_en_o, trig_tbl_o, fctr_aux_o;

    int ntests = 0;
    int nfail  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    uart_regbank i_uart_regbank (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .tx_level(tx_level), .rx_level(rx_level), .lcr_o(lcr_o), .ier_o(ier_o),
        .fcr_o(fcr_o), .mcr_o(mcr_o), .flow_en_o(flow_en_o), .trig_tbl_o(trig_tbl_o),
        .fctr_aux_o(fctr_aux_o), .ems_o(ems_o), .tx_trg_o(tx_trg_o), .rx_trg_o(rx_trg_o),
        .tx_fc_o(tx_fc_o), .rx_fc_o(rx_fc_o)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        ntests++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // monitor: pops the scoreboard while a read is presented
    always begin
        @(negedge clk);
        #1;
        if (host_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(host_rdata, e, t);
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic settle;
        @(negedge clk);
        #1;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(3'd1, 8'h00, "R1 ier");
        rd_chk(3'd2, 8'h00, "R1 fcr");
        rd_chk(3'd3, 8'h00, "R1 lcr");
        rd_chk(3'd4, 8'h00, "R1 mcr");
        rd_chk(3'd7, 8'h00, "R1 scratch");
        settle();
        chk(ems_o, 8'h00, "R1 ems_o");
        chk({6'd0, trig_tbl_o}, 8'h00, "R1 trig_tbl_o");

        // R4 gate closed: protected bits stay 0
        wr_reg(3'd1, 8'hFF); rd_chk(3'd1, 8'h0F, "R4 ier locked");
        wr_reg(3'd2, 8'h3F); rd_chk(3'd2, 8'h0F, "R4 fcr locked");
        wr_reg(3'd4, 8'hFF); rd_chk(3'd4, 8'h1F, "R4 mcr locked");
        // R7 scratch, R2 legacy map
        wr_reg(3'd7, 8'h5A); rd_chk(3'd7, 8'h5A, "R7 scratch");
        wr_reg(3'd3, 8'h03); rd_chk(3'd3, 8'h03, "R2 lcr");

        // R3 configuration window
        wr_reg(3'd3, 8'hBF);
        rd_chk(3'd3, 8'hBF, "R3 lcr in window");
        rd_chk(3'd1, 8'h00, "R3 fctr reset");
        wr_reg(3'd2, 8'hFF); rd_chk(3'd2, 8'hD0, "R6 efr reserved");
        settle(); chk({6'd0, flow_en_o}, 8'h03, "R6 efr high bits");
        wr_reg(3'd1, 8'hFF); rd_chk(3'd1, 8'hF3, "R6 fctr reserved");
        settle(); chk({6'd0, trig_tbl_o}, 8'h03, "R10 table D");
        // R9 steering to TX
        wr_reg(3'd4, 8'h21); wr_reg(3'd5, 8'h31);
        settle();
        chk(tx_trg_o, 8'h21, "R9 tx trigger");
        chk(rx_trg_o, 8'h00, "R9 rx trigger untouched");
        chk(tx_fc_o,  8'h31, "R9 tx flow");
        // steering to RX
        wr_reg(3'd1, 8'h03);
        wr_reg(3'd4, 8'h12); wr_reg(3'd5, 8'h13);
        rd_chk(3'd4, 8'h12, "R9 rx trigger read");
        rd_chk(3'd5, 8'h13, "R9 rx flow read");
        settle();
        chk(tx_trg_o, 8'h21, "R9 tx trigger untouched");
        chk(tx_fc_o,  8'h31, "R9 tx flow untouched");
        chk({6'd0, trig_tbl_o}, 8'h00, "R10 table A");
        chk({6'd0, fctr_aux_o}, 8'h03, "R6 fctr low bits");
        wr_reg(3'd1, 8'h93);
        rd_chk(3'd4, 8'h21, "R9 tx trigger read");
        settle(); chk({6'd0, trig_tbl_o}, 8'h01, "R10 table B");

        // leave window, gate open
        wr_reg(3'd3, 8'h03);
        rd_chk(3'd1, 8'h0F, "R3 ier kept after window");
        wr_reg(3'd1, 8'hA5); rd_chk(3'd1, 8'hA5, "R4 ier open");
        wr_reg(3'd2, 8'h35); rd_chk(3'd2, 8'h35, "R4 fcr open");
        wr_reg(3'd4, 8'hE1); rd_chk(3'd4, 8'hE1, "R4 mcr open");

        // R5 close gate, values retained
        wr_reg(3'd3, 8'hBF);
        wr_reg(3'd2, 8'h00); rd_chk(3'd2, 8'h00, "R5 efr closed");
        wr_reg(3'd3, 8'h03);
        wr_reg(3'd1, 8'h0C); rd_chk(3'd1, 8'hAC, "R5 ier retained");
        wr_reg(3'd4, 8'h02); rd_chk(3'd4, 8'hE2, "R5 mcr retained");
        wr_reg(3'd2, 8'h00); rd_chk(3'd2, 8'h30, "R5 fcr retained");
        rd_chk(3'd7, 8'h5A, "R7 scratch no swap");

        // R8 swap
        wr_reg(3'd3, 8'hBF); wr_reg(3'd1, 8'h40); wr_reg(3'd3, 8'h03);
        rd_chk(3'd7, 8'd17, "R8 rx level");
        wr_reg(3'd7, 8'h99);
        settle(); chk(ems_o, 8'h99, "R8 ems load");
        rd_chk(3'd7, 8'd17, "R8 rx level after write");
        wr_reg(3'd3, 8'hBF); wr_reg(3'd1, 8'hC0);
        rd_chk(3'd7, 8'd40, "R8 tx level");
        wr_reg(3'd1, 8'h00); wr_reg(3'd3, 8'h03);
        rd_chk(3'd7, 8'h5A, "R8 scratch kept");

        // R2 unused addresses
        wr_reg(3'd0, 8'h55); wr_reg(3'd5, 8'h77); wr_reg(3'd6, 8'h66);
        rd_chk(3'd0, 8'h00, "R2 addr0 reads 0");
        rd_chk(3'd5, 8'h00, "R2 addr5 reads 0");
        rd_chk(3'd6, 8'h00, "R2 addr6 reads 0");
        rd_chk(3'd1, 8'hAC, "R2 ier unchanged");
        rd_chk(3'd7, 8'h5A, "R2 scratch unchanged");
        settle();
        chk(rx_fc_o, 8'h13, "R2 rx flow unchanged");
        chk(tx_fc_o, 8'h31, "R2 tx flow unchanged");

        // R11 write timing and idle read data
        @(negedge clk);
        host_addr = 3'd7; host_wdata = 8'h66; host_wr = 1'b1; host_rd = 1'b1;
        #1 chk(host_rdata, 8'h5A, "R11 before edge");
        @(posedge clk);
        #1 chk(host_rdata, 8'h66, "R11 after edge");
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        #1 chk(host_rdata, 8'h00, "R11 rd low");

        wait (exp_q.size() == 0);
        settle();
        summary();
        $finish;
    end
endmodule